// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host side of a 32-bit serial readout link to a delta-sigma converter. From the system clock it generates a chip-select and a serial clock, shifts a configuration word out to the converter and captures the 32-bit result word in the same frame. While `run` is high it keeps reading frames back to back. Each frame both collects the result of the conversion that has just finished and sets up the conversion that the frame's last clock edge starts.

Completion can be detected in two ways, selected by `mode_busy`. With `mode_busy` low, chip-select stays low and the controller watches the data line: the converter drives it high while it converts and low once a result is ready. With `mode_busy` high, chip-select is released between frames and the controller waits for a separate busy input to drop. Each result is presented with a one-cycle valid pulse, a sign bit, a framing error flag and the channel tag. The tag comes from the configuration sent in the frame before, because a configuration only applies to the conversion that follows it. If completion is not seen within a programmable number of clocks, the controller gives up and reports a timeout.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sck` is low, and `res_valid` and `tmo_err` are low. `sck` is low whenever `cs_n` is high.
- R2: During a frame, each SCK high phase lasts exactly `div_half` clocks (`div_half` >= 2). A frame has exactly 32 rising SCK edges, and `sdo` is sampled at each rising edge.
- R3: `sdi` sends 32 bits, most significant first, and changes only while SCK is low. The bits in order are 1, 0, `cfg_en`, `cfg_sgl`, `cfg_odd`, `cfg_addr[1]`, `cfg_addr[0]`, `cfg_osr[3:0]`, `cfg_twox`, then 20 zeros. The fields are taken when the frame starts.
- R4: With `mode_busy` = 0, `cs_n` goes low on `run` and stays low through every frame and between frames. A frame begins only after `sdo` has been seen low. After a frame, the next one waits for `sdo` to go high and then low again.
- R5: With `mode_busy` = 1, `cs_n` is high while the controller waits, and a frame begins only after `busy` is low. `cs_n` goes high again at the end of each frame.
- R6: `res_valid` pulses for one clock, set by the clock edge that makes the 32nd falling SCK edge. Number the captured bits 31 (first) down to 0. `res_data` carries bits 28..0 and `res_sign` carries bit 29.
- R7: `res_frame_err` accompanies each result. It is 1 when captured bit 30 or bit 31 is 1.
- R8: `res_tag` is {sgl, odd, addr[1], addr[0]} of the configuration sent in the previous frame. For the first frame after reset it is 0.
- R9: If a wait for completion lasts more than `tmo_lim` clocks, `tmo_err` pulses for one clock and `cs_n` goes high. No result is produced. The pulse comes between `tmo_lim` and `tmo_lim`+3 clocks after `run` is raised.
- R10: When `run` is low at the end of a frame, or while the controller is waiting, it returns to idle with `cs_n` high and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep reading frames while high |
| mode_busy | input | 1 | 0: completion seen on sdo with CS low; 1: completion seen on busy with CS high |
| div_half | input | DIV_W | SCK half-period in system clocks (>= 2) |
| tmo_lim | input | TMO_W | Completion wait limit in clocks |
| cfg_en | input | 1 | Config: enable bit |
| cfg_sgl | input | 1 | Config: single-ended select |
| cfg_odd | input | 1 | Config: odd/polarity select |
| cfg_addr | input | 2 | Config: channel address |
| cfg_osr | input | 4 | Config: oversampling ratio code |
| cfg_twox | input | 1 | Config: double-speed select |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial configuration data to the converter |
| sdo | input | 1 | Serial data from the converter |
| busy | input | 1 | Converter busy indicator |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 29 | Captured bits 28..0 |
| res_sign | output | 1 | Captured bit 29 |
| res_frame_err | output | 1 | Framing error for this result |
| res_tag | output | 4 | {sgl, odd, addr} of the previous frame's config |
| tmo_err | output | 1 | One-cycle completion timeout pulse |

## Verification
A result is due on the same clock edge that pulls SCK low for the 32nd time. The monitor samples 1 ns after each rising clock edge and checks, whenever `res_valid` is seen, that SCK has just gone from high to low. It then pops the expected item from the scoreboard. A converter model acts on the falling system clock edge, a half cycle after each SCK change. It times every SCK high phase against `div_half`, collects `sdi` at each SCK rise for comparison with the word built from the configuration fields, and reports any frame that starts while it is converting. Timeouts are counted in clocks from the raising of `run`, and must fall within `tmo_lim` to `tmo_lim`+3.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;
    localparam int FRAME_LEN = 32;
    localparam int RES_W     = 29;
    localparam int CFG_W     = 10;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int PAD_W     = FRAME_LEN - CFG_W - 2;

    typedef struct packed {
        logic       en;
        logic       sgl;
        logic       odd;
        logic [1:0] addr;
        logic [3:0] osr;
        logic       twox;
    } cfg_t;

    typedef struct packed {
        logic       sgl;
        logic       odd;
        logic [1:0] addr;
    } tag_t;

    typedef struct packed {
        logic             eoc;
        logic             zero;
        logic             sign;
        logic [RES_W-1:0] mag;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ARM,
        ST_SHIFT
    } state_t;

    function automatic logic [FRAME_LEN-1:0] cmd_word(cfg_t c);
        return {2'b10, c, {PAD_W{1'b0}}};
    endfunction

    function automatic tag_t tag_of(cfg_t c);
        tag_t t;
        t.sgl  = c.sgl;
        t.odd  = c.odd;
        t.addr = c.addr;
        return t;
    endfunction
endpackage

// File: rtl/adcrd_sckgen.sv
`timescale 1ns/1ps
module adcrd_sckgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = en && (cnt == div - 1'b1);
    assign rise = wrap && !sck;
    assign fall = wrap && sck;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !en |=> !sck); // R1
    AST_SCK_HIGH_MIN: assert property (@(posedge clk) disable iff (rst) $rose(sck) |=> sck); // R2
endmodule

// File: rtl/adcrd_shifter.sv
`timescale 1ns/1ps
module adcrd_shifter
    import adcrd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [FRAME_LEN-1:0] load_word,
    input  logic                 sck,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 sdo,
    output logic                 sdi,
    output logic [FRAME_LEN-1:0] cap
);
    logic [FRAME_LEN-1:0] tx;

    assign sdi = tx[FRAME_LEN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx  <= '0;
            cap <= '0;
        end else begin
            if (load)
                tx <= load_word;
            else if (fall)
                tx <= {tx[FRAME_LEN-2:0], 1'b0};
            if (rise)
                cap <= {cap[FRAME_LEN-2:0], sdo};
        end
    end

    AST_SDI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(sdi)); // R3
endmodule

// File: rtl/adcrd_ctrl.sv
`timescale 1ns/1ps
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             mode_busy,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic             sdo,
    input  logic             busy,
    input  logic             fall,
    output logic             cs_n,
    output logic             sck_en,
    output logic             load,
    output logic             done,
    output logic             tmo_err
);
    state_t           st;
    logic             mode_q;
    logic [CNT_W-1:0] nfall;
    logic [TMO_W-1:0] wcnt;
    logic             ready;
    logic             tmo_hit;

    assign ready   = mode_q ? (busy == 1'b0) : (sdo == 1'b0);
    assign tmo_hit = (wcnt == tmo_lim);
    assign sck_en  = (st == ST_SHIFT);
    assign load    = (st == ST_WAIT) && run && ready;
    assign done    = (st == ST_SHIFT) && fall && (nfall == CNT_W'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cs_n    <= 1'b1;
            mode_q  <= 1'b0;
            nfall   <= '0;
            wcnt    <= '0;
            tmo_err <= 1'b0;
        end else begin
            tmo_err <= 1'b0;
            case (st)
                ST_IDLE: begin
                    cs_n <= 1'b1;
                    wcnt <= '0;
                    if (run) begin
                        mode_q <= mode_busy;
                        cs_n   <= mode_busy;
                        st     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!run) begin
                        st   <= ST_IDLE;
                        cs_n <= 1'b1;
                    end else if (ready) begin
                        st    <= ST_SHIFT;
                        cs_n  <= 1'b0;
                        nfall <= '0;
                    end else if (tmo_hit) begin
                        tmo_err <= 1'b1;
                        st      <= ST_IDLE;
                        cs_n    <= 1'b1;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_ARM: begin
                    if (!run) begin
                        st   <= ST_IDLE;
                        cs_n <= 1'b1;
                    end else if (sdo == 1'b1) begin
                        st   <= ST_WAIT;
                        wcnt <= wcnt + 1'b1;
                    end else if (tmo_hit) begin
                        tmo_err <= 1'b1;
                        st      <= ST_IDLE;
                        cs_n    <= 1'b1;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (fall)
                        nfall <= nfall + 1'b1;
                    if (done) begin
                        wcnt <= '0;
                        if (!run) begin
                            st   <= ST_IDLE;
                            cs_n <= 1'b1;
                        end else if (mode_q) begin
                            st   <= ST_WAIT;
                            cs_n <= 1'b1;
                        end else begin
                            st <= ST_ARM;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_CS_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT) |-> !cs_n); // R4
    AST_BUSY_WAIT_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && mode_q) |-> cs_n); // R5
    AST_TMO_RELEASES_CS: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> (cs_n && st == ST_IDLE)); // R9
    AST_NO_LOAD_WITHOUT_RUN: assert property (@(posedge clk) disable iff (rst)
        (!run && st != ST_SHIFT) |=> (st != ST_SHIFT)); // R10
endmodule

// File: rtl/adc_frame_reader.sv
`timescale 1ns/1ps
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             mode_busy,
    input  logic [DIV_W-1:0] div_half,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic             cfg_en,
    input  logic             cfg_sgl,
    input  logic             cfg_odd,
    input  logic [1:0]       cfg_addr,
    input  logic [3:0]       cfg_osr,
    input  logic             cfg_twox,
    output logic             cs_n,
    output logic             sck,
    output logic             sdi,
    input  logic             sdo,
    input  logic             busy,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             res_sign,
    output logic             res_frame_err,
    output logic [3:0]       res_tag,
    output logic             tmo_err
);
    cfg_t                 cfg_in;
    tag_t                 cur_tag;
    tag_t                 prev_tag;
    frame_t               fr;
    logic [FRAME_LEN-1:0] cap;
    logic                 sck_en, rise, fall, load, done;

    assign cfg_in.en   = cfg_en;
    assign cfg_in.sgl  = cfg_sgl;
    assign cfg_in.odd  = cfg_odd;
    assign cfg_in.addr = cfg_addr;
    assign cfg_in.osr  = cfg_osr;
    assign cfg_in.twox = cfg_twox;
    assign fr          = frame_t'(cap);

    adcrd_ctrl #(.TMO_W(TMO_W)) u_ctrl (
        .clk(clk), .rst(rst), .run(run), .mode_busy(mode_busy),
        .tmo_lim(tmo_lim), .sdo(sdo), .busy(busy), .fall(fall),
        .cs_n(cs_n), .sck_en(sck_en), .load(load), .done(done),
        .tmo_err(tmo_err)
    );

    adcrd_sckgen #(.DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst(rst), .en(sck_en), .div(div_half),
        .sck(sck), .rise(rise), .fall(fall)
    );

    adcrd_shifter u_shift (
        .clk(clk), .rst(rst), .load(load), .load_word(cmd_word(cfg_in)),
        .sck(sck), .rise(rise), .fall(fall), .sdo(sdo),
        .sdi(sdi), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_tag       <= '0;
            prev_tag      <= '0;
            res_valid     <= 1'b0;
            res_data      <= '0;
            res_sign      <= 1'b0;
            res_frame_err <= 1'b0;
            res_tag       <= '0;
        end else begin
            res_valid <= 1'b0;
            if (load)
                cur_tag <= tag_of(cfg_in);
            if (done) begin
                res_valid     <= 1'b1;
                res_data      <= fr.mag;
                res_sign      <= fr.sign;
                res_frame_err <= fr.zero | fr.eoc;
                res_tag       <= prev_tag;
                prev_tag      <= cur_tag;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R6
    AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck); // R1
    AST_NO_RESULT_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> !res_valid); // R9
endmodule

// File: tb/adc_frame_reader_bench.sv
`timescale 1ns/1ps
module adc_frame_reader_bench;
    import adcrd_pkg::*;

    typedef struct {
        logic [28:0] d;
        logic        s;
        logic        fe;
        logic [3:0]  tag;
    } exp_t;

    localparam int CONV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        mode_busy = 1'b0;
    logic [7:0]  div_half = 8'd2;
    logic [15:0] tmo_lim = 16'd500;
    logic        cfg_en = 1'b0, cfg_sgl = 1'b0, cfg_odd = 1'b0, cfg_twox = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [3:0]  cfg_osr = 4'd0;
    logic        cs_n, sck, sdi, sdo, busy;
    logic        res_valid, res_sign, res_frame_err, tmo_err;
    logic [28:0] res_data;
    logic [3:0]  res_tag;

    int   n_tests = 0;
    int   n_fail = 0;
    int   n_valid = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    // converter model state
    logic        dev_busy, dev_stuck = 1'b0, sck_prev;
    logic [31:0] dev_sh, sdi_cap, exp_sdi;
    int          dev_k, conv_cnt, rises, falls, hi_len;

    always #10 clk = ~clk;

    assign busy = dev_busy | dev_stuck;
    assign sdo  = cs_n ? 1'bz : (busy ? 1'b1 : dev_sh[31]);

    adc_frame_reader u_adc_frame_reader (
        .clk(clk), .rst(rst), .run(run), .mode_busy(mode_busy),
        .div_half(div_half), .tmo_lim(tmo_lim),
        .cfg_en(cfg_en), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd),
        .cfg_addr(cfg_addr), .cfg_osr(cfg_osr), .cfg_twox(cfg_twox),
        .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .res_sign(res_sign),
        .res_frame_err(res_frame_err), .res_tag(res_tag), .tmo_err(tmo_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dev_word(int k);
        logic [28:0] m;
        logic [31:0] kv;
        kv = k;
        m  = 29'((k + 1) * 3187459);
        return {1'b0, (k == 3), kv[0], m};
    endfunction

    function automatic logic [31:0] bench_sdi();
        return {1'b1, 1'b0, cfg_en, cfg_sgl, cfg_odd, cfg_addr, cfg_osr, cfg_twox, 20'd0};
    endfunction

    // converter model, acting half a cycle after each SCK change
    always @(negedge clk) begin
        if (rst) begin
            dev_busy = 1'b0; dev_sh = dev_word(0); dev_k = 1; sck_prev = 1'b0;
            rises = 0; falls = 0; hi_len = 0; conv_cnt = 0; sdi_cap = '0; exp_sdi = '0;
        end else begin
            if (!sck_prev && sck && !cs_n) begin
                if (rises == 0) begin
                    exp_sdi = bench_sdi();
                    check(!busy, "R4", "frame started while converting", 64'(busy), 64'd0);
                end
                sdi_cap = {sdi_cap[30:0], sdi};
                rises++;
                hi_len = 0;
            end
            if (sck) hi_len++;
            if (sck_prev && !sck) begin
                check(hi_len == int'(div_half), "R2", "SCK high phase length",
                      64'(hi_len), 64'(div_half));
                hi_len = 0;
                dev_sh = {dev_sh[30:0], 1'b0};
                falls++;
                if (falls == 32) begin
                    check(sdi_cap == exp_sdi, "R3", "SDI word", 64'(sdi_cap), 64'(exp_sdi));
                    check(rises == 32, "R2", "rising edges per frame", 64'(rises), 64'd32);
                    dev_busy = 1'b1; conv_cnt = CONV; falls = 0; rises = 0;
                end
            end else if (dev_busy) begin
                conv_cnt--;
                if (conv_cnt == 0) begin
                    dev_busy = 1'b0;
                    dev_sh = dev_word(dev_k);
                    dev_k++;
                end
            end
            sck_prev = sck;
        end
    end

    // monitor: pops the scoreboard when a result appears
    logic sck_seen = 1'b0;
    always @(posedge clk) begin
        #1;
        if (!rst && res_valid) begin
            check(sck_seen && !sck, "R6", "valid not on 32nd SCK fall", 64'(sck), 64'd0);
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected result", 64'(res_data), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_data == e.d, "R6", "result data", 64'(res_data), 64'(e.d));
                check(res_sign == e.s, "R6", "sign bit", 64'(res_sign), 64'(e.s));
                check(res_frame_err == e.fe, "R7", "frame error", 64'(res_frame_err), 64'(e.fe));
                check(res_tag == e.tag, "R8", "channel tag", 64'(res_tag), 64'(e.tag));
            end
            n_valid++;
        end
        sck_seen = sck;
    end

    int         widx = 0;
    int         gidx = 0;
    logic [3:0] last_tag = 4'd0;

    task automatic set_cfg(int g);
        logic [31:0] gv;
        gv = g;
        cfg_en = 1'b1; cfg_sgl = gv[0]; cfg_odd = gv[1]; cfg_addr = gv[3:2];
        cfg_osr = 4'(g * 3 + 1); cfg_twox = gv[2];
    endtask

    task automatic run_burst(bit mode, int dv, int n);
        mode_busy = mode;
        div_half = 8'(dv);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            logic [31:0] w;
            int target;
            set_cfg(gidx);
            w = dev_word(widx);
            e.d = w[28:0]; e.s = w[29]; e.fe = w[30] | w[31]; e.tag = last_tag;
            sb.push_back(e);
            last_tag = {cfg_sgl, cfg_odd, cfg_addr};
            widx++; gidx++;
            run = 1'b1;
            target = n_valid + 1;
            while (n_valid < target) @(posedge clk);
            #1;
            if (i < n - 1) begin
                if (mode)
                    check(cs_n == 1'b1, "R5", "CS released between frames", 64'(cs_n), 64'd1);
                else
                    check(cs_n == 1'b0, "R4", "CS held low between frames", 64'(cs_n), 64'd0);
            end
        end
        run = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(cs_n == 1'b1 && sck == 1'b0, "R10", "idle after run drop",
              64'({cs_n, sck}), 64'b10);
        repeat (CONV + 10) @(posedge clk);
        #1;
    endtask

    task automatic timeout_test(bit mode, int lim);
        int cnt;
        mode_busy = mode;
        tmo_lim = 16'(lim);
        dev_stuck = 1'b1;
        run = 1'b1;
        cnt = 0;
        while (cnt <= lim + 10) begin
            @(posedge clk);
            #1;
            cnt++;
            if (tmo_err) break;
        end
        run = 1'b0;
        check(tmo_err == 1'b1 && cnt >= lim && cnt <= lim + 3, "R9",
              "timeout clocks", 64'(cnt), 64'(lim + 2));
        check(cs_n == 1'b1, "R9", "CS high after timeout", 64'(cs_n), 64'd1);
        repeat (5) @(posedge clk);
        #1;
        dev_stuck = 1'b0;
        tmo_lim = 16'd500;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n after reset", 64'(cs_n), 64'd1);
        check(sck == 1'b0, "R1", "sck after reset", 64'(sck), 64'd0);
        check(res_valid == 1'b0 && tmo_err == 1'b0, "R1", "flags after reset",
              64'({res_valid, tmo_err}), 64'd0);

        run_burst(1'b0, 2, 5);     // EOC polling, frame 3 carries a framing error (R7)
        run_burst(1'b1, 5, 3);     // busy pin, wider SCK
        timeout_test(1'b1, 30);    // R9 busy mode
        timeout_test(1'b0, 45);    // R9 polling mode
        check(sb.size() == 0, "R9", "results pending after timeouts", 64'(sb.size()), 64'd0);
        run_burst(1'b0, 3, 2);     // tag continuity after timeouts (R8)
        check(sb.size() == 0, "R6", "all results delivered", 64'(sb.size()), 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule